// File: doc/BRIEF.md
# Split Two-Slot Ready-Valid Buffer

This block is an elastic buffer for one valid/ready link whose storage is divided across two neighbouring routing hops. The upstream hop (the head) and the downstream hop (the tail) each own one data register. Together they hold up to two words in flight. That is enough for a producer and a consumer to stream one word per clock while the consumer applies backpressure. A word moves across either edge only on a clock where valid and ready are both high on that edge.

With both hops storing, the tail register always holds the oldest word and drives the output. The head register fills only when the tail cannot take a word. When the tail is empty, or is draining, an arriving word passes through the head's multiplexer straight into the tail register. Upstream ready is taken from the two registered full flags alone, so no combinational path runs from the consumer's ready to the producer.

Each hop has its own static bypass bit. A bypassed hop is a plain wire for valid, ready and data, and it contributes no storage. The bypass bits are set while reset is held and stay unchanged during traffic.

Top module: `hop_pair_buffer`

## Requirements
- R1: A word is taken from upstream only on a clock where up_valid_i and up_ready_o are both high, and it is delivered only where dn_valid_o and dn_ready_i are both high. While the tail stores and the consumer holds dn_ready_i low, dn_valid_o stays high and dn_data_o stays unchanged.
- R2: Every accepted word leaves exactly once, in the order it was accepted. After the input goes idle and the output is left ready, the number of words delivered equals the number accepted.
- R3: The number of words held (accepted minus delivered) never exceeds the count of hops that store: 2 with no bypass, 1 with one hop bypassed, and 0 with both bypassed. With dn_ready_i held low and up_valid_i held high after reset, exactly that many words are accepted.
- R4: With both hops storing, up_ready_o is high exactly when fewer than two words are held, whatever up_valid_i and dn_ready_i do in the same clock.
- R5: With only the head storing (tail bypass bit = 1), up_ready_o is high exactly when the buffer is empty. dn_valid_o is high when a word is held or up_valid_i is high. When the buffer is empty, the input word appears at the output in the same clock.
- R6: With only the tail storing (head bypass bit = 1), up_ready_o is high when the buffer is empty or dn_ready_i is high, and dn_valid_o is high exactly when a word is held.
- R7: With both bypass bits = 1, the block is a wire: up_ready_o equals dn_ready_i, dn_valid_o equals up_valid_i, and dn_data_o equals up_data_i.
- R8: With both hops storing, dn_valid_o is high exactly when at least one word is held. A word accepted on one clock first appears at the output on the next clock.
- R9: With up_valid_i and dn_ready_i both held high from an empty state, one word is delivered on every clock from the first one on. In the configurations where the tail stores, the only exception is the first clock, so N clocks deliver N-1 words. Otherwise N clocks deliver N words.
- R10: An active-low asynchronous reset empties both registers, including when they were full. During reset, and right after it, dn_valid_o is low with the input idle. After reset, up_ready_o is high in every configuration except the all-bypass wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_head_byp_i | input | 1 | 1 = head hop is a wire, 0 = head hop stores one word |
| cfg_tail_byp_i | input | 1 | 1 = tail hop is a wire, 0 = tail hop stores one word |
| up_valid_i | input | 1 | Producer offers a word |
| up_ready_o | output | 1 | Buffer can take a word this clock |
| up_data_i | input | DATA_W | Producer word |
| dn_valid_o | output | 1 | Buffer offers a word to the consumer |
| dn_ready_i | input | 1 | Consumer takes the offered word this clock |
| dn_data_o | output | DATA_W | Word offered to the consumer |

## Verification
up_ready_o and dn_valid_o are functions of the held-word count, and of the same-clock inputs only where a hop is bypassed. They are therefore due in the same clock as the stimulus. A stored word becomes visible one rising edge after it is accepted. The bench applies inputs on the falling edge and samples the outputs 1 ns later, after the combinational paths settle and before the next rising edge. It updates its own accepted and delivered counts from the sampled handshakes, so each expectation uses the count that the intervening rising edge produced. Sweeps cover every bypass combination under several valid/ready patterns, a stalled fill, a full-rate run, and a reset taken while full.

// File: rtl/hop_pair_pkg.sv
package hop_pair_pkg;

    localparam int unsigned HOP_SLOTS_PER_STAGE = 1;

    typedef enum logic [1:0] {
        PM_BOTH_STORE = 2'b00,
        PM_HEAD_ONLY  = 2'b10,
        PM_TAIL_ONLY  = 2'b01,
        PM_WIRE       = 2'b11
    } pair_mode_e;

    function automatic pair_mode_e pair_mode(input logic head_byp, input logic tail_byp);
        return pair_mode_e'({tail_byp, head_byp});
    endfunction

    function automatic int unsigned pair_capacity(input logic head_byp, input logic tail_byp);
        int unsigned cap;
        cap = 0;
        if (!head_byp) cap = cap + HOP_SLOTS_PER_STAGE;
        if (!tail_byp) cap = cap + HOP_SLOTS_PER_STAGE;
        return cap;
    endfunction

endpackage

// File: rtl/hop_head_stage.sv
// Upstream hop: one register plus a pass-through path into the next hop.
// Its ready looks only at its own flag and the next hop's registered busy flag.
module hop_head_stage #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bypass_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [DATA_W-1:0] out_data_o,
    input  logic              next_busy_i
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  in_fire;

    always_comb begin
        slot_d  = slot_q;
        in_fire = 1'b0;
        if (bypass_i) begin
            in_ready_o  = out_ready_i;
            out_valid_o = in_valid_i;
            out_data_o  = in_data_i;
        end else begin
            in_ready_o  = !slot_q.full || !next_busy_i;
            out_valid_o = slot_q.full || in_valid_i;
            out_data_o  = slot_q.full ? slot_q.data : in_data_i;
            in_fire     = in_valid_i && in_ready_o;
            // Capture when a held word leaves while a new one arrives,
            // or when an arriving word cannot pass straight through.
            if (in_fire && (slot_q.full == out_ready_i)) begin
                slot_d.data = in_data_i;
            end
            if (slot_q.full) begin
                slot_d.full = out_ready_i ? in_fire : 1'b1;
            end else begin
                slot_d.full = in_fire && !out_ready_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

endmodule

// File: rtl/hop_tail_stage.sv
// Downstream hop: one output register; it reports its registered fullness
// upstream so that the head never needs the consumer's ready.
module hop_tail_stage #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bypass_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic [DATA_W-1:0] out_data_o,
    output logic              busy_o
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  in_fire;

    always_comb begin
        slot_d  = slot_q;
        in_fire = 1'b0;
        if (bypass_i) begin
            in_ready_o  = out_ready_i;
            out_valid_o = in_valid_i;
            out_data_o  = in_data_i;
        end else begin
            in_ready_o  = !slot_q.full || out_ready_i;
            out_valid_o = slot_q.full;
            out_data_o  = slot_q.data;
            in_fire     = in_valid_i && in_ready_o;
            slot_d.full = in_fire || (slot_q.full && !out_ready_i);
            if (in_fire) begin
                slot_d.data = in_data_i;
            end
        end
        busy_o = bypass_i || slot_q.full;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

endmodule

// File: rtl/hop_pair_buffer.sv
module hop_pair_buffer #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_head_byp_i,
    input  logic              cfg_tail_byp_i,
    input  logic              up_valid_i,
    output logic              up_ready_o,
    input  logic [DATA_W-1:0] up_data_i,
    output logic              dn_valid_o,
    input  logic              dn_ready_i,
    output logic [DATA_W-1:0] dn_data_o
);

    logic              mid_valid;
    logic              mid_ready;
    logic [DATA_W-1:0] mid_data;
    logic              tail_busy;

    hop_head_stage #(.DATA_W(DATA_W)) head_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bypass_i    (cfg_head_byp_i),
        .in_valid_i  (up_valid_i),
        .in_ready_o  (up_ready_o),
        .in_data_i   (up_data_i),
        .out_valid_o (mid_valid),
        .out_ready_i (mid_ready),
        .out_data_o  (mid_data),
        .next_busy_i (tail_busy)
    );

    hop_tail_stage #(.DATA_W(DATA_W)) tail_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bypass_i    (cfg_tail_byp_i),
        .in_valid_i  (mid_valid),
        .in_ready_o  (mid_ready),
        .in_data_i   (mid_data),
        .out_valid_o (dn_valid_o),
        .out_ready_i (dn_ready_i),
        .out_data_o  (dn_data_o),
        .busy_o      (tail_busy)
    );

endmodule

// File: rtl/hop_pair_buffer_chk.sv
module hop_pair_buffer_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cfg_head_byp_i,
    input logic              cfg_tail_byp_i,
    input logic              up_valid_i,
    input logic              up_ready_o,
    input logic              dn_valid_o,
    input logic              dn_ready_i,
    input logic [DATA_W-1:0] dn_data_o
);
    import hop_pair_pkg::*;

    logic [2:0]  held_q;
    logic        up_fire;
    logic        dn_fire;
    logic [2:0]  cap;
    pair_mode_e  mode;

    assign up_fire = up_valid_i && up_ready_o;
    assign dn_fire = dn_valid_o && dn_ready_i;
    assign cap     = 3'(pair_capacity(cfg_head_byp_i, cfg_tail_byp_i));
    assign mode    = pair_mode(cfg_head_byp_i, cfg_tail_byp_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            held_q <= '0;
        end else begin
            held_q <= held_q + 3'(up_fire) - 3'(dn_fire);
        end
    end

    // R1
    hold_until_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_tail_byp_i && dn_valid_o && !dn_ready_i) |=> (dn_valid_o && $stable(dn_data_o)));

    // R3
    occupancy_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        held_q <= cap);

    // R4
    ready_from_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == PM_BOTH_STORE) |-> (up_ready_o == (held_q < 3'd2)));

    // R8
    empty_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == PM_BOTH_STORE && held_q == 3'd0) |-> !dn_valid_o);

    // R7
    wire_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode == PM_WIRE) |-> (up_ready_o == dn_ready_i && dn_valid_o == up_valid_i));

    // R10
    always @(posedge clk_i) begin
        if (!rst_ni && !cfg_tail_byp_i) begin
            reset_empty_chk: assert (!dn_valid_o) else $error("output valid during reset");
        end
    end

endmodule

bind hop_pair_buffer hop_pair_buffer_chk #(.DATA_W(DATA_W)) chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cfg_head_byp_i (cfg_head_byp_i),
    .cfg_tail_byp_i (cfg_tail_byp_i),
    .up_valid_i     (up_valid_i),
    .up_ready_o     (up_ready_o),
    .dn_valid_o     (dn_valid_o),
    .dn_ready_i     (dn_ready_i),
    .dn_data_o      (dn_data_o)
);

// File: tb/hop_pair_buffer_tb_top.sv
module hop_pair_buffer_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         hbyp, tbyp;
    logic         up_valid, up_ready, dn_valid, dn_ready;
    logic [W-1:0] up_data, dn_data;

    int checks = 0;
    int errors = 0;
    int tx = 0;
    int rx = 0;

    always #4 clk = ~clk;

    hop_pair_buffer #(.DATA_W(W)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .cfg_head_byp_i (hbyp),
        .cfg_tail_byp_i (tbyp),
        .up_valid_i     (up_valid),
        .up_ready_o     (up_ready),
        .up_data_i      (up_data),
        .dn_valid_o     (dn_valid),
        .dn_ready_i     (dn_ready),
        .dn_data_o      (dn_data)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (head_byp=%0b tail_byp=%0b)",
                     req, what, act, exp, hbyp, tbyp);
        end
    endtask

    function automatic int capacity();
        return (hbyp ? 0 : 1) + (tbyp ? 0 : 1);
    endfunction

    // One clock: drive on the falling edge, sample 1 ns later.
    task automatic step(input bit v, input bit r);
        int occ;
        bit exp_rdy, exp_val;
        string req;
        @(negedge clk);
        up_valid = v;
        dn_ready = r;
        up_data  = tx[W-1:0];
        #1;
        occ = tx - rx;
        if (!hbyp && !tbyp) begin
            exp_rdy = occ < 2;            req = "R4/R8";
            exp_val = occ > 0;
        end else if (!hbyp && tbyp) begin
            exp_rdy = occ == 0;           req = "R5";
            exp_val = (occ > 0) || v;
        end else if (hbyp && !tbyp) begin
            exp_rdy = (occ == 0) || r;    req = "R6";
            exp_val = occ > 0;
        end else begin
            exp_rdy = r;                  req = "R7";
            exp_val = v;
        end
        chk(up_ready == exp_rdy, req, "up_ready", int'(up_ready), int'(exp_rdy));
        chk(dn_valid == exp_val, req, "dn_valid", int'(dn_valid), int'(exp_val));
        if (dn_valid) begin
            // R2: the oldest undelivered sequence number is at the output
            chk(dn_data == rx[W-1:0], "R2", "dn_data", int'(dn_data), rx & 16'hFFFF);
        end
        if (v && up_ready) tx++;
        if (dn_valid && r) rx++;
        // R3
        chk((tx - rx) <= capacity(), "R3", "held words", tx - rx, capacity());
    endtask

    task automatic do_reset(input bit hb, input bit tb);
        @(negedge clk);
        rst_n    = 1'b0;
        hbyp     = hb;
        tbyp     = tb;
        up_valid = 1'b0;
        dn_ready = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        // R10: empty during reset
        chk(dn_valid == 1'b0, "R10", "dn_valid in reset", int'(dn_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        tx = 0;
        rx = 0;
        #1;
        chk(dn_valid == 1'b0, "R10", "dn_valid after reset", int'(dn_valid), 0);
        chk(up_ready == !(hb && tb), "R10", "up_ready after reset", int'(up_ready), int'(!(hb && tb)));
    endtask

    function automatic bit pat_v(input int p, input int i);
        case (p)
            0: return 1'b1;
            1: return 1'b1;
            2: return i[0];
            3: return (i % 5) < 3;
            4: return 1'b1;
            default: return ((i * 37 + 11) >> 2) & 1;
        endcase
    endfunction

    function automatic bit pat_r(input int p, input int i);
        case (p)
            0: return 1'b1;
            1: return (i % 3) != 0;
            2: return 1'b1;
            3: return (i % 7) < 2;
            4: return i >= 8;
            default: return ((i * 53 + 13) >> 3) & 1;
        endcase
    endfunction

    initial begin
        rst_n    = 1'b0;
        hbyp     = 1'b0;
        tbyp     = 1'b0;
        up_valid = 1'b0;
        dn_ready = 1'b0;
        up_data  = '0;
        for (int cfg = 0; cfg < 4; cfg++) begin
            bit hb = cfg[0];
            bit tb = cfg[1];
            int got;

            // R9: full rate with both sides always willing
            do_reset(hb, tb);
            for (int i = 0; i < 20; i++) step(1'b1, 1'b1);
            got = rx;
            chk(got == (tb ? 20 : 19), "R9", "words in 20 clocks", got, tb ? 20 : 19);

            // R3: stalled fill accepts exactly the capacity
            do_reset(hb, tb);
            for (int i = 0; i < 6; i++) step(1'b1, 1'b0);
            chk(tx == capacity(), "R3", "accepted under stall", tx, capacity());
            // R1: stalled word remains offered and unchanged
            if (!tb) chk(dn_valid == 1'b1, "R1", "held dn_valid", int'(dn_valid), 1);

            // R10: reset taken while holding words
            do_reset(hb, tb);

            // R1/R2: patterned traffic, then drain
            for (int p = 0; p < 6; p++) begin
                for (int i = 0; i < 64; i++) step(pat_v(p, i), pat_r(p, i));
                for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
                chk(tx == rx, "R2", "delivered vs accepted", rx, tx);
                chk(tx > 0, "R1", "words accepted", tx, 1);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule